// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash bus. It waits for an internal program or erase operation to finish. The caller must first issue the full command sequence: four write pulses for a program, six for an erase. After the last write pulse the caller raises `start_i` and supplies four items: the operation kind, an address inside the unprotected target sector, the data it expects to find there, and an overall timeout in clock cycles. The poller then performs back-to-back read cycles on that address and watches status bit 6. While that bit flips from one read to the next, the device is still busy.

Two consecutive reads can show the same bit 6 value. The outputs of a finishing device may still be settling at that point, so the poller does not take that read as the result. It performs exactly one further confirmation read, and the data from that read is the final data. The poller then reports one of three outcomes. The operation may complete normally, with a pass/fail comparison against the expected data. Toggling may stop suspiciously early with the wrong data, which is treated as an abort on a protected sector. Or the overall timeout may expire.

Top module: `tbpoll_ctrl`

## Requirements
- R1: Out of reset and whenever the poller is not busy, `flash_ce_no` and `flash_oe_no` are both high, `busy_o` is 0 and `done_o` is 0.
- R2: `start_i` is accepted only when not busy. While busy, `start_i`, `addr_i` and the other request inputs are ignored, so the bus address, the read timing and the outcome are unchanged.
- R3: Each read cycle lasts SETUP_CYC+OE_CYC+1 cycles. Chip and output enables are high for SETUP_CYC cycles, then both are low for OE_CYC cycles, then both are high for one evaluation cycle. The data is sampled in the last low cycle. The first read begins in the cycle after the start is accepted, and reads follow each other with no gap.
- R4: `flash_addr_o` takes `addr_i` when a start is accepted. It changes only in cycles where both enables are high.
- R5: The status bit is `flash_dq_i[6]`. If its value in a read differs from its value in the previous read, or if the read is the first one of the operation, another read follows. The only exception is the timeout of R10.
- R6: If a read shows the same bit 6 value as the previous read, exactly one confirmation read follows, whatever the timeout. The operation ends after that confirmation read, and its data is the final data whatever its bit 6.
- R7: `done_o` is a one-cycle pulse in the cycle after the evaluation cycle of the last read. `busy_o` goes low in that same cycle, and a new start may be accepted in that cycle.
- R8: `result_o` is valid while `done_o` is high. The codes are 2'b00 completed, 2'b01 protected abort and 2'b10 timeout. `pass_o` is 1 only when the result is completed and the final data equals `exp_data_i`.
- R9: The result is protected abort when two conditions hold: the final data differs from the expected data, and the elapsed count at the final evaluation is below the protection window. The window is PROG_PROT_CYC for a program (`erase_i`=0) and ERASE_PROT_CYC for an erase (`erase_i`=1). Elapsed is 0 in the first busy cycle and rises by 1 each cycle.
- R10: At an evaluation that neither finishes a confirmation nor starts one, the poller checks the elapsed count. If it is at or above `timeout_lim_i`, the operation ends with result timeout and `pass_o`=0.
- R11: A mismatching final data value at or after the protection window gives result completed with `pass_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (after last command write pulse) |
| erase_i | input | 1 | 1 = erase operation, 0 = program |
| addr_i | input | AW | Poll address inside the target sector |
| exp_data_i | input | DW | Data expected once the operation ends |
| timeout_lim_i | input | TW | Overall timeout in clock cycles |
| flash_addr_o | output | AW | Flash address bus |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_dq_i | input | DW | Flash data bus |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle end-of-poll pulse |
| result_o | output | 2 | Outcome code, see R8 |
| pass_o | output | 1 | Final data matched expectation |

## Verification
The hardest case to reach is a pair of reads whose bit 6 values agree while the data is still not final. That case must not be taken as the result. Only the confirmation read may be. The bench's device responder can return one intermediate word that copies the previous status bit but carries wrong data, and a correct poller must still report the value of the following read.

The protected-abort rule depends on the elapsed count and on the operation kind. The stimulus therefore sends the same early-finishing, mismatching device script once as a program and once as an erase. The timeout rule is tested at the limit and one cycle above it. A further case sets the timeout so that it expires during a pending confirmation, which must still complete.

// File: rtl/tbpoll_pkg.sv
package tbpoll_pkg;
  typedef enum logic [1:0] {
    RES_DONE = 2'b00,
    RES_PROT = 2'b01,
    RES_TMO  = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_SETUP,
    RD_STROBE
  } rd_st_e;
endpackage

// File: rtl/tbpoll_rdcyc.sv
module tbpoll_rdcyc
  import tbpoll_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SETUP_CYC = 1,
  parameter int OE_CYC    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] dq_i,
  output logic          ce_no,
  output logic          oe_no,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  localparam int MAXC = (SETUP_CYC > OE_CYC) ? SETUP_CYC : OE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  rd_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic          vld_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RD_IDLE;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      unique case (st_q)
        RD_IDLE: begin
          if (go_i) begin
            st_q  <= RD_SETUP;
            cnt_q <= '0;
          end
        end
        RD_SETUP: begin
          if (cnt_q == CW'(SETUP_CYC - 1)) begin
            st_q  <= RD_STROBE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RD_STROBE: begin
          if (cnt_q == CW'(OE_CYC - 1)) begin
            st_q   <= RD_IDLE;
            data_q <= dq_i;
            vld_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RD_IDLE;
      endcase
    end
  end

  // address is never touched while strobing, so both strobes move together
  assign ce_no  = (st_q != RD_STROBE);
  assign oe_no  = (st_q != RD_STROBE);
  assign vld_o  = vld_q;
  assign data_o = data_q;

  // strobe width checker
  logic [CW:0] low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_run_q <= '0;
    else if (!oe_no) low_run_q <= low_run_q + 1'b1;
    else             low_run_q <= '0;
  end

  AST_STROBE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_no) |-> (low_run_q == (CW+1)'(OE_CYC))) else $error("strobe width"); // R3

  AST_GO_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (st_q == RD_IDLE)) else $error("read request while busy"); // R3
endmodule

// File: rtl/tbpoll_timer.sv
module tbpoll_timer #(
  parameter int TW             = 24,
  parameter int PROG_PROT_CYC  = 50,
  parameter int ERASE_PROT_CYC = 20000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          erase_i,
  input  logic [TW-1:0] lim_i,
  output logic          tmo_o,
  output logic          in_win_o
);
  localparam int PWB = $clog2(PROG_PROT_CYC + 1);
  localparam int EWB = $clog2(ERASE_PROT_CYC + 1);
  localparam int WW  = (PWB > EWB) ? PWB : EWB;
  localparam int EW  = (TW > WW) ? TW : WW;

  logic [EW-1:0] el_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        el_q <= '0;
    else if (clr_i)                     el_q <= '0;
    else if (run_i && (el_q != '1))     el_q <= el_q + 1'b1;
  end

  assign tmo_o    = (el_q >= EW'(lim_i));
  assign in_win_o = erase_i ? (el_q < EW'(ERASE_PROT_CYC))
                            : (el_q < EW'(PROG_PROT_CYC));

  AST_EL_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |=> (el_q >= $past(el_q))) else $error("elapsed went back"); // R10
endmodule

// File: rtl/tbpoll_judge.sv
module tbpoll_judge
  import tbpoll_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TB_BIT = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          eval_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] exp_i,
  input  logic          tmo_i,
  input  logic          in_win_i,
  output logic          fin_o,
  output res_e          res_o,
  output logic          pass_o
);
  logic have_q, prev_q, conf_q;
  logic tb, settle, match;

  assign tb     = data_i[TB_BIT];
  assign match  = (data_i == exp_i);
  assign settle = have_q && (tb == prev_q);

  // a pending confirmation always completes, timeout only between reads
  assign fin_o  = eval_i && (conf_q || (!settle && tmo_i));

  always_comb begin
    if (conf_q) res_o = (in_win_i && !match) ? RES_PROT : RES_DONE;
    else        res_o = RES_TMO;
  end
  assign pass_o = conf_q && match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      conf_q <= 1'b0;
    end else if (clr_i) begin
      have_q <= 1'b0;
      conf_q <= 1'b0;
    end else if (eval_i && !fin_o) begin
      have_q <= 1'b1;
      prev_q <= tb;
      conf_q <= settle;
    end
  end

  AST_CONF_NEEDS_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conf_q) |-> have_q) else $error("confirm without history"); // R6
endmodule

// File: rtl/tbpoll_ctrl.sv
module tbpoll_ctrl
  import tbpoll_pkg::*;
#(
  parameter int AW             = 21,
  parameter int DW             = 16,
  parameter int TB_BIT         = 6,
  parameter int SETUP_CYC      = 1,
  parameter int OE_CYC         = 3,
  parameter int TW             = 24,
  parameter int PROG_PROT_CYC  = 50,
  parameter int ERASE_PROT_CYC = 20000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [TW-1:0] timeout_lim_i,
  output logic [AW-1:0] flash_addr_o,
  output logic          flash_ce_no,
  output logic          flash_oe_no,
  input  logic [DW-1:0] flash_dq_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          pass_o
);
  logic          busy_q, done_q, pass_q, erase_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [TW-1:0] lim_q;
  res_e          res_q;

  logic          accept, go, vld, fin, tmo, in_win, pass_c;
  logic [DW-1:0] rd_data;
  res_e          res_c;

  assign accept = start_i && !busy_q;
  assign go     = accept || (vld && !fin);

  tbpoll_rdcyc #(.DW(DW), .SETUP_CYC(SETUP_CYC), .OE_CYC(OE_CYC)) u_rd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .dq_i  (flash_dq_i),
    .ce_no (flash_ce_no),
    .oe_no (flash_oe_no),
    .vld_o (vld),
    .data_o(rd_data)
  );

  tbpoll_timer #(.TW(TW), .PROG_PROT_CYC(PROG_PROT_CYC),
                 .ERASE_PROT_CYC(ERASE_PROT_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .run_i   (busy_q),
    .erase_i (erase_q),
    .lim_i   (lim_q),
    .tmo_o   (tmo),
    .in_win_o(in_win)
  );

  tbpoll_judge #(.DW(DW), .TB_BIT(TB_BIT)) u_jdg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .eval_i  (vld),
    .data_i  (rd_data),
    .exp_i   (exp_q),
    .tmo_i   (tmo),
    .in_win_i(in_win),
    .fin_o   (fin),
    .res_o   (res_c),
    .pass_o  (pass_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      erase_q <= 1'b0;
      addr_q  <= '0;
      exp_q   <= '0;
      lim_q   <= '0;
      res_q   <= RES_DONE;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        erase_q <= erase_i;
        addr_q  <= addr_i;
        exp_q   <= exp_data_i;
        lim_q   <= timeout_lim_i;
      end else if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= res_c;
        pass_q <= pass_c;
      end
    end
  end

  assign flash_addr_o = addr_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign pass_o       = pass_q;

  AST_IDLE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (flash_ce_no && flash_oe_no)) else $error("bus active while idle"); // R1

  AST_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_addr_o != $past(flash_addr_o)) |-> (flash_ce_no && flash_oe_no)) else $error("addr moved under strobe"); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than a cycle"); // R7

  AST_DONE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done while busy"); // R7

  AST_PASS_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (result_o == RES_DONE)) else $error("pass with bad result"); // R8
endmodule

// File: tb/tbpoll_ctrl_test.sv
module tbpoll_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21, DW = 16, TW = 16;
  localparam int SETUP_CYC = 1, OE_CYC = 3;
  localparam int PROG_WIN = 30, ERASE_WIN = 400;
  localparam int P = SETUP_CYC + OE_CYC + 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start_i = 1'b0, erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] exp_i = '0;
  logic [TW-1:0] lim_i = '0;
  logic [AW-1:0] f_addr;
  logic          f_ce_n, f_oe_n;
  logic [DW-1:0] f_dq;
  logic          busy, done, pass;
  logic [1:0]    res;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbpoll_ctrl #(.AW(AW), .DW(DW), .TB_BIT(6), .SETUP_CYC(SETUP_CYC), .OE_CYC(OE_CYC),
                .TW(TW), .PROG_PROT_CYC(PROG_WIN), .ERASE_PROT_CYC(ERASE_WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .erase_i(erase_i),
    .addr_i(addr_i), .exp_data_i(exp_i), .timeout_lim_i(lim_i),
    .flash_addr_o(f_addr), .flash_ce_no(f_ce_n), .flash_oe_no(f_oe_n),
    .flash_dq_i(f_dq), .busy_o(busy), .done_o(done), .result_o(res), .pass_o(pass)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // behavioural device
  int            sc_ntog = 0;
  bit            sc_glitch = 0;
  logic [DW-1:0] sc_final = '0;
  int            rd_idx = 0;

  function automatic logic [DW-1:0] dev_val(input int k);
    logic [DW-1:0] v;
    if (k < sc_ntog) v = 16'h2A00 | ((k % 2 == 1) ? 16'h0040 : 16'h0000);
    else if (k == sc_ntog && sc_glitch)
      v = (16'h5A15 & ~16'h0040) | (((sc_ntog - 1) % 2 == 1) ? 16'h0040 : 16'h0000);
    else v = sc_final;
    return v;
  endfunction

  always @(posedge f_oe_n) rd_idx++;
  always_comb f_dq = (!f_ce_n && !f_oe_n) ? dev_val(rd_idx) : 16'h0000;

  // reference model, compared every cycle
  bit            m_busy, m_done, m_pass, m_have, m_prev, m_conf, m_erase;
  int            m_t, m_k, m_lim;
  logic [1:0]    m_res;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_exp;
  int            cyc = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
    if (!rst_n) begin
      chk(f_ce_n === 1'b1 && f_oe_n === 1'b1, "R1 strobes in reset", {f_ce_n, f_oe_n}, 2'b11);
      chk(busy === 1'b0 && done === 1'b0, "R1 busy/done in reset", {busy, done}, 2'b00);
      m_busy = 0; m_done = 0; m_addr = '0; m_t = 0; m_k = 0;
    end else begin
      bit strobe, nd;
      int ph;
      ph = m_t % P;
      strobe = m_busy && (ph >= SETUP_CYC) && (ph < SETUP_CYC + OE_CYC);
      chk(f_ce_n === !strobe, m_busy ? "R3 ce_n" : "R1 ce_n", f_ce_n, !strobe);
      chk(f_oe_n === !strobe, m_busy ? "R3 oe_n" : "R1 oe_n", f_oe_n, !strobe);
      chk(busy === m_busy, "R2 busy", busy, m_busy);
      chk(done === m_done, "R7 done", done, m_done);
      chk(f_addr === m_addr, "R4 addr", f_addr, m_addr);
      if (m_done) begin
        chk(res === m_res, "R8 result", res, m_res);
        chk(pass === m_pass, "R8 pass", pass, m_pass);
      end
      nd = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; m_t = 0; m_k = 0; m_have = 0; m_conf = 0;
          m_addr = addr_i; m_erase = erase_i; m_exp = exp_i; m_lim = int'(lim_i);
        end
      end else if (ph == P - 1) begin
        logic [DW-1:0] d;
        bit tb, fin;
        d = dev_val(m_k);
        tb = d[6];
        fin = 0;
        if (m_conf) begin
          fin = 1;
          m_res = (m_t < (m_erase ? ERASE_WIN : PROG_WIN) && d != m_exp) ? 2'b01 : 2'b00;
          m_pass = (m_res == 2'b00) && (d == m_exp);
        end else if (m_have && tb == m_prev) begin
          m_conf = 1;
        end else if (m_t >= m_lim) begin
          fin = 1; m_res = 2'b10; m_pass = 0;
        end
        if (fin) begin
          m_busy = 0; nd = 1;
        end else begin
          m_have = 1; m_prev = tb; m_k++; m_t++;
        end
      end else begin
        m_t++;
      end
      m_done = nd;
    end
  end

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] ex,
                        input logic [DW-1:0] fin_v, input int ntog, input bit gl,
                        input int lim, input bit inject, input logic [1:0] e_res,
                        input bit e_pass, input int e_n, input string tag);
    int n;
    sc_ntog = ntog; sc_glitch = gl; sc_final = fin_v; rd_idx = 0;
    @(posedge clk); #2;
    start_i = 1; erase_i = er; addr_i = a; exp_i = ex; lim_i = TW'(lim);
    n = 0;
    while (1) begin
      @(posedge clk); #2;
      n++;
      if (n == 1) begin start_i = 0; addr_i = '0; erase_i = ~er; exp_i = ~ex; end
      if (inject && n == 10) begin start_i = 1; addr_i = 21'h0ABCD; erase_i = ~er; end
      if (inject && n == 11) start_i = 0;
      if (done) break;
      if (n > 5000) break;
    end
    chk(done === 1'b1, {tag, " finished"}, done, 1);
    chk(res === e_res, {tag, " result"}, res, e_res);
    chk(pass === e_pass, {tag, " pass"}, pass, e_pass);
    if (e_n > 0) chk(n == e_n, {tag, " latency"}, n, e_n);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (2) @(posedge clk);
    // R5 toggling then stable, final read matches
    run_op(0, 21'h01234, 16'h1234, 16'h1234, 6, 0, 60000, 0, 2'b00, 1, 46, "R5 program ok");
    // R6 settling word copies toggle bit, confirm read carries final data
    run_op(0, 21'h00100, 16'h1234, 16'h1234, 6, 1, 60000, 0, 2'b00, 1, 41, "R6 glitch confirm");
    // R9 early stop with wrong data on a program
    run_op(0, 21'h00200, 16'h1234, 16'h00FF, 2, 0, 60000, 0, 2'b01, 0, 21, "R9 program prot");
    // R11 same data late on a program
    run_op(0, 21'h00300, 16'h1234, 16'h00FF, 12, 0, 60000, 0, 2'b00, 0, 71, "R11 late mismatch");
    // R9 identical script as erase falls in the longer window
    run_op(1, 21'h00400, 16'h1234, 16'h00FF, 12, 0, 60000, 0, 2'b01, 0, 71, "R9 erase prot");
    // R8 long erase passes
    run_op(1, 21'h1F000, 16'hFFFF, 16'hFFFF, 100, 0, 60000, 0, 2'b00, 1, 511, "R8 erase ok");
    // R10 timeout at the limit and one past it
    run_op(0, 21'h00500, 16'h1234, 16'h1234, 1000000, 0, 204, 0, 2'b10, 0, 206, "R10 tmo at lim");
    run_op(0, 21'h00600, 16'h1234, 16'h1234, 1000000, 0, 205, 0, 2'b10, 0, 211, "R10 tmo lim+1");
    // R10 timeout passes during pending confirmation: still completes
    run_op(0, 21'h00700, 16'h0040, 16'h0040, 2, 0, 10, 0, 2'b00, 1, 21, "R10 confirm wins");
    // R2 start mid-operation is ignored
    run_op(0, 21'h00800, 16'h1234, 16'h1234, 6, 0, 60000, 1, 2'b00, 1, 46, "R2 start ignored");
    repeat (3) @(posedge clk);
    summary();
  end
endmodule